// File: doc/BRIEF.md
# Delay-Line Tap Decoder with Bubble Suppression

This block is the digital back end of a tapped-delay-line time-to-digital converter. A stop edge captures the state of every delay tap at one instant; taps the start edge has already passed read 1 and the rest read 0. The captured word arrives on `in_taps` together with a one-cycle `in_valid` strobe. The block cleans isolated bubble errors left by noise or metastability, locates the position of the 1-to-0 transition and reports it as a binary fine-time code, where one code step equals one stage delay.

Bubble cleanup is a three-tap majority vote applied to every tap, with an implicit 1 below tap 0 and an implicit 0 above the last tap. The code is the index of the highest tap that reads 1 after cleanup, plus one, so a word of all zeros gives code 0 and a word of all ones gives code N. Two flags mark measurements outside the line's reach: underflow when no tap is set after cleanup (the start edge has reached no tap) and overflow when every tap is set (the start edge has run past the end of the line). The result is registered, so it appears one clock after the strobe with a matching output strobe.

Top module: `tdc_therm_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `out_valid`, `out_code`, `out_underflow` and `out_overflow` are all 0.
- R2: `out_valid` is high in exactly those cycles that follow a clock edge at which `in_valid` was high.
- R3: A clean thermometer word with taps 0..k-1 at 1 and the rest at 0 (0 < k < N) yields `out_code` = k with both flags low.
- R4: A single tap that disagrees with both of its neighbours is corrected before encoding: an isolated 0 inside the run of ones or an isolated 1 inside the run of zeros does not move the code.
- R5: For any tap word, each cleaned tap i equals the majority of raw taps i-1, i, i+1 (tap -1 taken as 1, tap N taken as 0), and `out_code` equals the highest cleaned index at 1, plus one, or 0 if none.
- R6: When every cleaned tap is 1, `out_overflow` is 1, `out_underflow` is 0 and `out_code` saturates at N.
- R7: When every cleaned tap is 0, `out_underflow` is 1, `out_overflow` is 0 and `out_code` is 0; this also covers a lone 1 on the top tap.
- R8: The end padding acts on the edge taps: a lone 1 on tap 0 yields code 1, and a word of ones with only the top tap at 0 yields code N-1 without overflow.
- R9: In a cycle where `in_valid` was low at the preceding edge, `out_code` and both flags keep the values of the last accepted word regardless of `in_taps`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_taps` holds a captured word |
| in_taps | input | N_TAPS | Captured tap states, bit 0 is the first tap |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_code | output | $clog2(N_TAPS+1) | Fine time code in stage delays |
| out_underflow | output | 1 | No tap set after cleanup |
| out_overflow | output | 1 | All taps set after cleanup |

## Verification
Bubble suppression and range flagging can decide the same word: whether a flag rises depends on whether a stray tap survives the vote. This is provoked with a lone 1 on the top tap (the vote removes it and underflow must rise), a full word with one interior 0 (the vote fills it and overflow must rise) and a full word whose top tap is 0 (no overflow, code N-1). Random words mixing clean thermometers with a few flipped taps are judged against a bench model built from the majority rule and the highest-set-tap rule.

// File: rtl/tdc_dec_pkg.sv
package tdc_dec_pkg;

    // Default tap count of the delay line.
    localparam int unsigned TAPS_DEFAULT = 64;

    // Range flags reported with every result.
    typedef struct packed {
        logic underflow;
        logic overflow;
    } range_flags_t;

    // Majority of three bits.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tdc_bubble_vote.sv
module tdc_bubble_vote
    import tdc_dec_pkg::*;
#(
    parameter int unsigned N_TAPS = TAPS_DEFAULT
) (
    input  logic [N_TAPS-1:0] raw_taps,
    output logic [N_TAPS-1:0] clean_taps
);

    // Implicit 1 below tap 0 and implicit 0 above the last tap.
    logic [N_TAPS+1:0] padded;
    assign padded = {1'b0, raw_taps, 1'b1};

    for (genvar i = 0; i < N_TAPS; i++) begin : g_vote
        assign clean_taps[i] = maj3(padded[i], padded[i+1], padded[i+2]);
    end

endmodule

// File: rtl/tdc_edge_encode.sv
module tdc_edge_encode
    import tdc_dec_pkg::*;
#(
    parameter int unsigned N_TAPS = TAPS_DEFAULT,
    localparam int unsigned CODE_W = $clog2(N_TAPS + 1)
) (
    input  logic [N_TAPS-1:0] clean_taps,
    output logic [CODE_W-1:0] code,
    output range_flags_t      flags
);

    // Highest set index plus one; later iterations win.
    always_comb begin
        code = '0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (clean_taps[i]) begin
                code = CODE_W'(i + 1);
            end
        end
    end

    always_comb begin
        flags.underflow = ~|clean_taps;
        flags.overflow  = &clean_taps;
    end

endmodule

// File: rtl/tdc_therm_decoder.sv
module tdc_therm_decoder
    import tdc_dec_pkg::*;
#(
    parameter int unsigned N_TAPS = TAPS_DEFAULT,
    localparam int unsigned CODE_W = $clog2(N_TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_TAPS-1:0] in_taps,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic              out_underflow,
    output logic              out_overflow
);

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
        range_flags_t      flags;
    } result_t;

    logic [N_TAPS-1:0] clean_taps;
    logic [CODE_W-1:0] enc_code;
    range_flags_t      enc_flags;
    result_t           res_d, res_q;

    tdc_bubble_vote #(.N_TAPS(N_TAPS)) u_vote (
        .raw_taps  (in_taps),
        .clean_taps(clean_taps)
    );

    tdc_edge_encode #(.N_TAPS(N_TAPS)) u_enc (
        .clean_taps(clean_taps),
        .code      (enc_code),
        .flags     (enc_flags)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.code  = enc_code;
            res_d.flags = enc_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid     = res_q.vld;
    assign out_code      = res_q.code;
    assign out_underflow = res_q.flags.underflow;
    assign out_overflow  = res_q.flags.overflow;

endmodule

// File: rtl/tdc_therm_decoder_chk.sv
module tdc_therm_decoder_chk #(
    parameter int unsigned N_TAPS = 64,
    parameter int unsigned CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CODE_W-1:0] out_code,
    input logic              out_valid,
    input logic              out_underflow,
    input logic              out_overflow
);

    // R2: strobe follows input strobe by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6: overflow saturates the code and excludes underflow
    p_over_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> (out_code == CODE_W'(N_TAPS)) && !out_underflow);

    // R7: underflow coincides with code zero
    p_under_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_underflow == (out_code == '0)));

    // R5: code never exceeds the tap count
    p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_code <= CODE_W'(N_TAPS));

    // R9: results hold without a strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code) && $stable(out_underflow) && $stable(out_overflow));

endmodule

bind tdc_therm_decoder tdc_therm_decoder_chk #(
    .N_TAPS(N_TAPS),
    .CODE_W(CODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_code     (out_code),
    .out_valid    (out_valid),
    .out_underflow(out_underflow),
    .out_overflow (out_overflow)
);

// File: tb/tb_tdc_therm_decoder.sv
`timescale 1ns/1ps
module tb_tdc_therm_decoder;

    localparam int N  = 64;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_taps = '0;
    logic          out_valid;
    logic [CW-1:0] out_code;
    logic          out_underflow;
    logic          out_overflow;

    int n_checks = 0;
    int n_fail   = 0;
    logic [CW-1:0] last_code = '0;
    logic          last_under = 1'b0;
    logic          last_over  = 1'b0;

    always #2.5 clk = ~clk;

    tdc_therm_decoder #(.N_TAPS(N)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_taps(in_taps),
        .out_valid(out_valid), .out_code(out_code),
        .out_underflow(out_underflow), .out_overflow(out_overflow)
    );

    // Majority cleanup with 1 below tap 0 and 0 above the top tap.
    function automatic logic [N-1:0] ref_clean(input logic [N-1:0] t);
        logic [N-1:0] c;
        for (int i = 0; i < N; i++) begin
            logic lo, hi;
            lo = (i == 0) ? 1'b1 : t[i-1];
            hi = (i == N-1) ? 1'b0 : t[i+1];
            c[i] = (lo & t[i]) | (lo & hi) | (t[i] & hi);
        end
        return c;
    endfunction

    function automatic logic [CW-1:0] ref_code(input logic [N-1:0] t);
        logic [N-1:0] c;
        logic [CW-1:0] r;
        c = ref_clean(t);
        r = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (c[i] && r == '0) r = CW'(i + 1);
        end
        return r;
    endfunction

    function automatic logic [N-1:0] therm(input int k);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i < k);
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one word, check the registered result at the following negedge.
    task automatic apply(input string req, input logic [N-1:0] t);
        logic [N-1:0] c;
        c = ref_clean(t);
        @(negedge clk);
        in_taps  = t;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        last_code  = ref_code(t);
        last_under = (c == '0);
        last_over  = &c;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " code"},  32'(out_code), 32'(last_code));
        check({req, " under"}, 32'(out_underflow), 32'(last_under));
        check({req, " over"},  32'(out_overflow), 32'(last_over));
    endtask

    // R9: idle cycle with changed taps; outputs must hold.
    task automatic idle_hold(input logic [N-1:0] t);
        in_taps = t;
        @(negedge clk);
        check("R9/R2 idle valid", 32'(out_valid), 32'd0);
        check("R9 held code", 32'(out_code), 32'(last_code));
        check("R9 held under", 32'(out_underflow), 32'(last_under));
        check("R9 held over", 32'(out_overflow), 32'(last_over));
    endtask

    initial begin : watchdog
        #(150000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] v;
        void'($urandom(32'd20240611));
        in_taps = {N{1'b1}};
        #12;
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset code", 32'(out_code), 32'd0);
        check("R1 reset flags", 32'({out_underflow, out_overflow}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release valid", 32'(out_valid), 32'd0);
        check("R1 after release code", 32'(out_code), 32'd0);

        apply("R3 clean k=1", therm(1));
        apply("R3 clean k=20", therm(20));
        apply("R3 clean k=63", therm(63));
        check("R3 k=63 code", 32'(out_code), 32'd63);
        v = therm(40); v[10] = 1'b0;
        apply("R4 isolated zero", v);
        check("R4 zero bubble code", 32'(out_code), 32'd40);
        v = therm(12); v[30] = 1'b1;
        apply("R4 isolated one", v);
        check("R4 one bubble code", 32'(out_code), 32'd12);
        idle_hold(therm(5));
        apply("R6 all ones", {N{1'b1}});
        check("R6 overflow", 32'(out_overflow), 32'd1);
        check("R6 saturated code", 32'(out_code), 32'(N));
        v = {N{1'b1}}; v[33] = 1'b0;
        apply("R6 ones with interior bubble", v);
        check("R6 bubble overflow", 32'(out_overflow), 32'd1);
        apply("R7 all zeros", '0);
        check("R7 underflow", 32'(out_underflow), 32'd1);
        v = '0; v[N-1] = 1'b1;
        apply("R7 lone top tap", v);
        check("R7 top tap underflow", 32'(out_underflow), 32'd1);
        v = '0; v[0] = 1'b1;
        apply("R8 lone tap0", v);
        check("R8 tap0 code", 32'(out_code), 32'd1);
        v = {N{1'b1}}; v[N-1] = 1'b0;
        apply("R8 top tap low", v);
        check("R8 top low code", 32'(out_code), 32'(N-1));
        check("R8 top low no overflow", 32'(out_overflow), 32'd0);
        idle_hold('0);

        for (int n = 0; n < 300; n++) begin
            int k;
            int flips;
            k = int'($urandom_range(0, N));
            v = therm(k);
            flips = int'($urandom_range(0, 3));
            for (int f = 0; f < flips; f++) begin
                int p;
                p = int'($urandom_range(0, N-1));
                v[p] = ~v[p];
            end
            if (n % 25 == 0) v = {$urandom, $urandom};
            apply("R5 random", v);
            if (n % 4 == 0) idle_hold({$urandom, $urandom});
        end

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule